// File: doc/BRIEF.md
# Daisy-Chained Interrupt Requester

This block is the card-side half of a prioritised backplane interrupt scheme. A local device pulses an event strobe. The block then raises one of seven request lines, chosen by a configured level. Level 7 carries the highest priority and level 1 the lowest. A configured level of 0 keeps all lines quiet. A system handler answers a request by starting an acknowledge cycle: it asserts the address strobe, presents the level it is servicing, and sends an acknowledge token down a chain of cards.

Each card on the chain sees the token on its chain input. The first card that holds a pending request at the serviced level keeps the token and does not pass it on. It places its configured 8-bit vector on the low data lines and signals transfer complete. Every other card passes the token to its chain output. Cards that share a level therefore take priority from their position on the chain, and the returned vector tells the handler which card raised the request.

Top module: `irq_chain_requester`

## Requirements
- R1: After synchronous reset, every request line, the chain output, the data enable, the transfer-complete output and the data lines are all 0.
- R2: One clock after an event strobe, with configured level L in 1..7, the request output is one-hot with bit L-1 set (bit k-1 stands for level k). It stays so until the request is claimed. With level 0, no request bit is set.
- R3: The block claims an acknowledge when address strobe and chain input are both high, a request is pending, and the acknowledged level equals the nonzero configured level. One clock later, data enable and transfer-complete are 1, the data lines carry the vector, and the chain output stays 0.
- R4: If the block is not claiming, it sets the chain output to 1 one clock after it sees address strobe and chain input both high. It holds that value until the strobe falls and never drives data or transfer-complete.
- R5: One clock after address strobe falls, the chain output, data enable and transfer-complete are 0, and the data lines read 0.
- R6: The request output reads all zero from the clock in which the claim takes effect.
- R7: An event strobe that arrives during a claimed cycle is held back. The request is raised again one clock after address strobe falls.
- R8: Several event strobes while a request is pending produce one claim only. The next acknowledge at that level is passed on.
- R9: With two cards chained at the same level, both pending, the upstream card claims the first acknowledge and the downstream card returns no transfer-complete. The second acknowledge passes through the upstream card, and the downstream card claims it with its own vector.
- R10: The vector is captured when the claim is made. A change to the configured vector during the cycle does not alter the data lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 1 | Local event strobe, one clock per event |
| cfg_level_i | input | 3 | Configured request level, 0 disables |
| cfg_vector_i | input | 8 | Configured vector returned on a claim |
| ack_level_i | input | 3 | Level being acknowledged |
| as_i | input | 1 | Address strobe, high during an acknowledge cycle |
| iack_in_i | input | 1 | Acknowledge token from the upstream card |
| irq_o | output | 7 | One-hot request lines, bit k-1 for level k |
| iack_out_o | output | 1 | Acknowledge token to the downstream card |
| data_o | output | 8 | Vector on the low data lines |
| data_oe_o | output | 1 | Data drive enable |
| dtack_o | output | 1 | Transfer-complete acknowledge |

## Verification
A lost pending flag shows up the clock after the event, as a request line that never rises, or as a pass where a claim was due. A flag that fails to clear on a claim shows up in the same cycle as a request line still high during the transfer. It shows up again at the next acknowledge, as a second claim. A chain controller stuck in the wrong state shows, one clock after address strobe changes, as the token and the transfer-complete disagreeing, or as outputs that stay driven after the strobe falls. A second card wired downstream exposes a token that leaks past a claiming card, because the downstream card then answers as well.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_PASS  = 2'd1,
        CH_CLAIM = 2'd2
    } chain_st_e;

    typedef struct packed {
        logic claim;   // acknowledge taken this cycle
        logic active;  // inside a claimed cycle
        logic done;    // claimed cycle ends at this edge
    } cyc_ev_t;

    function automatic logic level_match(input logic [2:0] mine,
                                         input logic [2:0] acked);
        return (mine != 3'd0) && (mine == acked);
    endfunction

endpackage

// File: rtl/irq_pend_track.sv
module irq_pend_track
    import irq_req_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    evt_i,
    input  cyc_ev_t ev_i,
    output logic    pend_o
);
    logic pend_q;
    logic held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            held_q <= 1'b0;
        end else if (ev_i.claim) begin
            pend_q <= 1'b0;
            held_q <= evt_i;
        end else if (ev_i.active) begin
            if (ev_i.done) begin
                pend_q <= held_q | evt_i;
                held_q <= 1'b0;
            end else begin
                held_q <= held_q | evt_i;
            end
        end else begin
            pend_q <= pend_q | evt_i;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/iack_chain_ctl.sv
module iack_chain_ctl
    import irq_req_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             as_i,
    input  logic             iack_in_i,
    input  logic [LVL_W-1:0] ack_level_i,
    input  logic [LVL_W-1:0] cfg_level_i,
    input  logic             pend_i,
    output chain_st_e        st_o,
    output cyc_ev_t          ev_o,
    output logic             iack_out_o
);
    chain_st_e st_q, st_d;
    logic      hit;

    assign hit = pend_i && level_match(cfg_level_i, ack_level_i);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_IDLE:  if (as_i && iack_in_i) st_d = hit ? CH_CLAIM : CH_PASS;
            CH_PASS:  if (!as_i) st_d = CH_IDLE;
            CH_CLAIM: if (!as_i) st_d = CH_IDLE;
            default:  st_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= CH_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        ev_o.claim  = (st_q == CH_IDLE) && (st_d == CH_CLAIM);
        ev_o.active = (st_q == CH_CLAIM);
        ev_o.done   = (st_q == CH_CLAIM) && !as_i;
    end

    assign st_o       = st_q;
    assign iack_out_o = (st_q == CH_PASS);
endmodule

// File: rtl/irq_level_dec.sv
module irq_level_dec #(
    parameter int LVL_W   = 3,
    parameter int NUM_LVL = 7
) (
    input  logic [LVL_W-1:0]   level_i,
    input  logic               req_i,
    output logic [NUM_LVL-1:0] irq_o
);
    for (genvar k = 1; k <= NUM_LVL; k++) begin : g_line
        assign irq_o[k-1] = req_i && (level_i == LVL_W'(k));
    end
endmodule

// File: rtl/vec_hold.sv
module vec_hold #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [VEC_W-1:0] vec_i,
    input  logic             drive_i,
    output logic [VEC_W-1:0] data_o,
    output logic             data_oe_o,
    output logic             dtack_o
);
    logic [VEC_W-1:0] vec_q;

    always_ff @(posedge clk) begin
        if (rst)         vec_q <= '0;
        else if (load_i) vec_q <= vec_i;
    end

    assign data_o    = drive_i ? vec_q : '0;
    assign data_oe_o = drive_i;
    assign dtack_o   = drive_i;
endmodule

// File: rtl/irq_chain_requester.sv
module irq_chain_requester
    import irq_req_pkg::*;
#(
    parameter int LVL_W = 3,
    parameter int VEC_W = 8,
    localparam int NUM_LVL = (1 << LVL_W) - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               evt_i,
    input  logic [LVL_W-1:0]   cfg_level_i,
    input  logic [VEC_W-1:0]   cfg_vector_i,
    input  logic [LVL_W-1:0]   ack_level_i,
    input  logic               as_i,
    input  logic               iack_in_i,
    output logic [NUM_LVL-1:0] irq_o,
    output logic               iack_out_o,
    output logic [VEC_W-1:0]   data_o,
    output logic               data_oe_o,
    output logic               dtack_o
);
    chain_st_e st;
    cyc_ev_t   ev;
    logic      pend;

    irq_pend_track u_pend (
        .clk(clk), .rst(rst), .evt_i(evt_i), .ev_i(ev), .pend_o(pend)
    );

    iack_chain_ctl #(.LVL_W(LVL_W)) u_chain (
        .clk(clk), .rst(rst), .as_i(as_i), .iack_in_i(iack_in_i),
        .ack_level_i(ack_level_i), .cfg_level_i(cfg_level_i),
        .pend_i(pend), .st_o(st), .ev_o(ev), .iack_out_o(iack_out_o)
    );

    irq_level_dec #(.LVL_W(LVL_W), .NUM_LVL(NUM_LVL)) u_dec (
        .level_i(cfg_level_i), .req_i(pend && (st != CH_CLAIM)), .irq_o(irq_o)
    );

    vec_hold #(.VEC_W(VEC_W)) u_vec (
        .clk(clk), .rst(rst), .load_i(ev.claim), .vec_i(cfg_vector_i),
        .drive_i(st == CH_CLAIM), .data_o(data_o),
        .data_oe_o(data_oe_o), .dtack_o(dtack_o)
    );
endmodule

// File: rtl/irq_chain_requester_chk.sv
module irq_chain_requester_chk #(
    parameter int LVL_W = 3,
    parameter int VEC_W = 8,
    parameter int NUM_LVL = 7
) (
    input logic               clk,
    input logic               rst,
    input logic               as_i,
    input logic               iack_in_i,
    input logic [LVL_W-1:0]   ack_level_i,
    input logic [LVL_W-1:0]   cfg_level_i,
    input logic [NUM_LVL-1:0] irq_o,
    input logic               iack_out_o,
    input logic               data_oe_o,
    input logic               dtack_o,
    input logic [VEC_W-1:0]   data_o
);
    // R2
    irq_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_o));

    // R3
    claim_blocks_token_chk: assert property (@(posedge clk) disable iff (rst)
        dtack_o |-> !iack_out_o);

    // R3
    claim_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dtack_o) |-> $past(as_i && iack_in_i && ack_level_i == cfg_level_i
                                 && irq_o != '0));

    // R4
    pass_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(iack_out_o) |-> $past(as_i && iack_in_i));

    // R5
    release_chk: assert property (@(posedge clk) disable iff (rst)
        !as_i |=> (!dtack_o && !data_oe_o && !iack_out_o && data_o == '0));

    // R6
    req_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        dtack_o |-> (irq_o == '0));
endmodule

bind irq_chain_requester irq_chain_requester_chk #(
    .LVL_W(LVL_W), .VEC_W(VEC_W), .NUM_LVL(NUM_LVL)
) u_chk (
    .clk(clk), .rst(rst), .as_i(as_i), .iack_in_i(iack_in_i),
    .ack_level_i(ack_level_i), .cfg_level_i(cfg_level_i), .irq_o(irq_o),
    .iack_out_o(iack_out_o), .data_oe_o(data_oe_o), .dtack_o(dtack_o),
    .data_o(data_o)
);

// File: tb/tb_irq_chain_requester.sv
module tb_irq_chain_requester;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic       evt = 0, evt2 = 0;
    logic [2:0] lvl = 0, lvl2 = 0, ack_lvl = 0;
    logic [7:0] vec = 0, vec2 = 0;
    logic       as = 0, iack_in = 0;

    logic [6:0] irq, irq2;
    logic       iack_mid, iack_end;
    logic [7:0] dat, dat2;
    logic       oe, oe2, dtk, dtk2;

    irq_chain_requester dut (
        .clk(clk), .rst(rst), .evt_i(evt), .cfg_level_i(lvl), .cfg_vector_i(vec),
        .ack_level_i(ack_lvl), .as_i(as), .iack_in_i(iack_in), .irq_o(irq),
        .iack_out_o(iack_mid), .data_o(dat), .data_oe_o(oe), .dtack_o(dtk)
    );

    irq_chain_requester dut2 (
        .clk(clk), .rst(rst), .evt_i(evt2), .cfg_level_i(lvl2), .cfg_vector_i(vec2),
        .ack_level_i(ack_lvl), .as_i(as), .iack_in_i(iack_mid), .irq_o(irq2),
        .iack_out_o(iack_end), .data_o(dat2), .data_oe_o(oe2), .dtack_o(dtk2)
    );

    int nchk = 0, nfail = 0;
    bit finished = 0;

    // fields: {level, vector, acknowledged level}
    localparam logic [13:0] TBL [6] = '{
        {3'd1, 8'h40, 3'd1},
        {3'd7, 8'hFF, 3'd7},
        {3'd4, 8'h64, 3'd3},
        {3'd6, 8'h81, 3'd6},
        {3'd2, 8'h00, 3'd5},
        {3'd0, 8'h55, 3'd0}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] onehot(input logic [2:0] l);
        return (l == 0) ? 7'd0 : 7'(1 << (l - 1));
    endfunction

    task automatic pulse_evt();
        evt = 1; tick(); evt = 0;
    endtask

    task automatic start_ack(input logic [2:0] l);
        ack_lvl = l; as = 1; iack_in = 1; tick();
    endtask

    task automatic end_ack();
        as = 0; iack_in = 0; tick();
    endtask

    task automatic do_reset();
        rst = 1; tick(); tick(); rst = 0; tick();
    endtask

    initial begin
        do_reset();
        // R1 reset state
        check(irq == 0 && iack_mid == 0 && oe == 0 && dtk == 0 && dat == 0,
              "R1", {irq, iack_mid, oe, dtk, dat}, 0);

        for (int i = 0; i < 6; i++) begin
            logic [2:0] l, a;
            logic [7:0] v;
            bit claim;
            {l, v, a} = TBL[i];
            claim = (l != 0) && (l == a);
            lvl = l; vec = v;
            pulse_evt();
            check(irq == onehot(l), "R2", irq, onehot(l));
            start_ack(a);
            if (claim) begin
                check(dtk && oe && dat == v && !iack_mid, "R3", {dtk, oe, iack_mid, dat}, {3'b110, v});
                check(irq == 0, "R6", irq, 0);
            end else begin
                check(iack_mid && !dtk && !oe, "R4", {iack_mid, dtk, oe}, 3'b100);
                check(irq == onehot(l), "R4", irq, onehot(l));
            end
            tick();
            check(dtk == claim && iack_mid == !claim, "R4", {dtk, iack_mid}, {claim, !claim});
            end_ack();
            check(!dtk && !oe && !iack_mid && dat == 0, "R5", {dtk, oe, iack_mid, dat}, 0);
            if (!claim && l != 0) begin
                start_ack(l);
                check(dtk && dat == v, "R3", dat, v);
                end_ack();
            end
        end

        // R7: event during claimed cycle is deferred
        do_reset();
        lvl = 3'd5; vec = 8'h3C;
        pulse_evt();
        start_ack(3'd5);
        pulse_evt();
        check(irq == 0 && dtk, "R7", irq, 0);
        end_ack();
        check(irq == onehot(3'd5), "R7", irq, onehot(3'd5));
        start_ack(3'd5);
        check(dtk && dat == 8'h3C, "R7", dat, 8'h3C);
        end_ack();

        // R8: repeated events give one claim
        lvl = 3'd2; vec = 8'h9A;
        pulse_evt(); pulse_evt(); pulse_evt();
        start_ack(3'd2);
        check(dtk && dat == 8'h9A, "R8", dat, 8'h9A);
        end_ack();
        check(irq == 0, "R8", irq, 0);
        start_ack(3'd2);
        check(iack_mid && !dtk, "R8", {iack_mid, dtk}, 2'b10);
        end_ack();

        // R10: vector captured at claim
        lvl = 3'd4; vec = 8'h11;
        pulse_evt();
        start_ack(3'd4);
        vec = 8'hEE;
        tick();
        check(dat == 8'h11, "R10", dat, 8'h11);
        end_ack();

        // R9: two cards sharing a level
        do_reset();
        lvl = 3'd3; vec = 8'hA1; lvl2 = 3'd3; vec2 = 8'hB2;
        evt = 1; evt2 = 1; tick(); evt = 0; evt2 = 0;
        start_ack(3'd3);
        check(dtk && dat == 8'hA1 && !iack_mid, "R9", dat, 8'hA1);
        tick(); tick();
        check(!dtk2 && irq2 == onehot(3'd3), "R9", {dtk2, irq2}, {1'b0, onehot(3'd3)});
        end_ack();
        start_ack(3'd3);
        check(iack_mid && !dtk, "R9", {iack_mid, dtk}, 2'b10);
        tick();
        check(dtk2 && dat2 == 8'hB2 && !iack_end, "R9", dat2, 8'hB2);
        end_ack();
        check(!dtk2 && !iack_mid, "R5", {dtk2, iack_mid}, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule